// File: doc/BRIEF.md
# I2C Bus Condition and Byte Engine

This block is the bit-level core of a single-master I2C controller. A control word written by software enables the engine and issues bus commands: a START, a repeated START or a STOP. Single bytes are written through a separate data strobe. The engine produces the matching waveforms on SCL and SDA through open-drain enables. It sends each byte most significant bit first and then releases SDA for a ninth clock. The level seen on SDA during that ninth clock is the acknowledge, and it is kept as a not-acknowledged status bit.

Timing comes from a programmable divider. Every bus bit or bus condition is built from four quarters, and each quarter lasts `qdiv + 1` enabled clock cycles. An external clock-enable freezes the engine, and a pad-off input floats both lines whatever the engine holds. A busy flag covers each operation from the accepting edge to its last quarter. A sticky done flag marks each finished operation until software clears it.

Top module: `i2c_bus_engine`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy_o` and `done_o` are 0 and `ctl_rdata` reads 0.
- R2: A control write made while idle stores the enable in bit 0 and the command in bits [2:1]. Command 0 and command 3 mean no action, 1 means START/repeated START, and 2 means STOP. `ctl_rdata` returns the not-acknowledged flag in bit 3, the stored command in bits [2:1] and the enable in bit 0.
- R3: A command or byte write has no effect on the bus, `busy_o` or `ctl_rdata` if the enable is 0 or the engine is busy. A control write made while busy is dropped completely.
- R4: A START (command 1, bit 3 = 0) makes SDA fall while SCL is high and leaves both lines held low. It completes `4*(qdiv+1)` enabled cycles after the accepting edge.
- R5: A repeated START (command 1, bit 3 = 1) keeps SCL low for the first quarter and then makes a START condition, with the same duration as R4.
- R6: A byte write shifts the byte out MSB first, one bit per SCL high period, and then gives a ninth clock with SDA released. The operation completes `36*(qdiv+1)` enabled cycles after the accepting edge.
- R7: After a byte, `ctl_rdata[3]` equals the SDA level sampled during the ninth SCL high period: 1 means not acknowledged.
- R8: A STOP (command 2) makes SDA rise while SCL is high, completes in `4*(qdiv+1)` enabled cycles, and leaves both lines released.
- R9: `busy_o` is high from the cycle after an accepted write until the operation completes. At completion `done_o` is set, and it stays set until a `done_clr` pulse.
- R10: While `clk_en` is 0, the engine does not advance: busy and the line enables hold their values, and the completion time is extended by the stalled cycles.
- R11: While `pad_off` is 1, `scl_oe` and `sda_oe` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control word: enable, command, modifier |
| ctl_rdata | output | 4 | Control readback: {nack, command, enable} |
| dat_wr | input | 1 | Data byte write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| done_clr | input | 1 | Clears the done flag |
| clk_en | input | 1 | Timing clock enable |
| pad_off | input | 1 | Floats both bus lines when 1 |
| qdiv | input | DIV_W | Quarter-period length minus one, in clock cycles |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Sticky operation-complete flag |

## Verification
The engine accepts a write at the clock edge where the strobe is seen. `busy_o` is due one cycle after that edge. `done_o` and the end of `busy_o` are due exactly 4 or 36 quarters of `qdiv+1` cycles later, plus any cycles with `clk_en` low. The line enables trail the internal quarter by one register. The bench drives strobes on falling edges and counts falling edges from the accepting edge until `done_o` appears, then compares that count with the formula. Bus-level results are checked only after completion: the START and STOP events, the nine captured bits and the sampled acknowledge. Readback and line levels are sampled on the falling edge after the relevant write.

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_wdata,
  output logic [3:0]       ctl_rdata,
  input  logic             dat_wr,
  input  logic [7:0]       dat_wdata,
  input  logic             done_clr,
  input  logic             clk_en,
  input  logic             pad_off,
  input  logic [DIV_W-1:0] qdiv,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  typedef enum logic [1:0] {OP_IDLE, OP_START, OP_STOP, OP_BYTE} op_t;

  op_t              op;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [DIV_W-1:0] cnt;
  logic [7:0]       shreg;
  logic             rmod, en_r, nack_r, done_r, scl_lo, sda_lo;
  logic [1:0]       cmd_r;
  logic             scl_d, sda_d;

  wire idle   = (op == OP_IDLE);
  wire tick   = !idle && clk_en && (cnt == qdiv);
  wire last_q = (q == 2'd3);
  wire op_end = tick && last_q && (op != OP_BYTE || bitn == LAST_BIT);
  wire cmd_ok = (ctl_wdata[2:1] == 2'd1) || (ctl_wdata[2:1] == 2'd2);
  wire ctl_go = ctl_wr && idle && ctl_wdata[0] && cmd_ok;
  wire dat_go = dat_wr && !ctl_wr && idle && en_r;

  always_comb begin
    scl_d = scl_lo;
    sda_d = sda_lo;
    case (op)
      OP_START: begin
        scl_d = (q == 2'd0 && rmod) || last_q;
        sda_d = q[1];
      end
      OP_STOP: begin
        scl_d = (q == 2'd0);
        sda_d = !q[1];
      end
      OP_BYTE: begin
        scl_d = (q == 2'd0) || last_q;
        sda_d = (bitn != LAST_BIT) && !shreg[7];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op     <= OP_IDLE;
      q      <= '0;
      bitn   <= '0;
      cnt    <= '0;
      shreg  <= '0;
      rmod   <= 1'b0;
      en_r   <= 1'b0;
      cmd_r  <= '0;
      nack_r <= 1'b0;
      done_r <= 1'b0;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
    end else begin
      if (ctl_wr && idle) begin
        en_r  <= ctl_wdata[0];
        cmd_r <= ctl_wdata[2:1];
      end
      if (ctl_go) begin
        op   <= (ctl_wdata[2:1] == 2'd1) ? OP_START : OP_STOP;
        rmod <= ctl_wdata[3];
        q    <= '0;
        cnt  <= '0;
      end else if (dat_go) begin
        op    <= OP_BYTE;
        shreg <= dat_wdata;
        bitn  <= '0;
        q     <= '0;
        cnt   <= '0;
      end else if (!idle && clk_en) begin
        if (cnt == qdiv) begin
          cnt <= '0;
          q   <= q + 2'd1;
          if (op == OP_BYTE && q == 2'd2 && bitn == LAST_BIT)
            nack_r <= sda_in;
          if (last_q) begin
            if (op == OP_BYTE && bitn != LAST_BIT) begin
              bitn  <= bitn + 4'd1;
              shreg <= {shreg[6:0], 1'b0};
            end else begin
              op <= OP_IDLE;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (op_end)        done_r <= 1'b1;
      else if (done_clr) done_r <= 1'b0;
      if (!idle) begin
        scl_lo <= scl_d;
        sda_lo <= sda_d;
      end
    end
  end

  assign scl_oe    = scl_lo && !pad_off;
  assign sda_oe    = sda_lo && !pad_off;
  assign busy_o    = !idle;
  assign done_o    = done_r;
  assign ctl_rdata = {nack_r, cmd_r, en_r};
endmodule

// File: rtl/i2c_bus_engine_chk.sv
module i2c_bus_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [3:0] ctl_wdata,
  input logic [3:0] ctl_rdata,
  input logic       dat_wr,
  input logic       clk_en,
  input logic       pad_off,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy_o,
  input logic       done_o
);
  assert_launch_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy_o && ctl_wdata[0] && ctl_wdata[2:1] == 2'd1) |=> busy_o);

  assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[0] && !busy_o && !dat_wr) |=> !busy_o);

  assert_readback_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy_o) |=> (ctl_rdata[0] == $past(ctl_wdata[0])));

  assert_stall_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !clk_en && $past(!clk_en)) |=>
      (busy_o && ($stable(pad_off) -> ($stable(scl_oe) && $stable(sda_oe)))));

  assert_pad_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pad_off |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_bus_engine i2c_bus_engine_chk u_chk (.*);

// File: tb/i2c_bus_engine_tb.sv
module i2c_bus_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, dat_wr = 1'b0, done_clr = 1'b0;
  logic       clk_en = 1'b1, pad_off = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic [7:0] dat_wdata = '0;
  logic [7:0] qdiv = 8'd1;
  logic [3:0] ctl_rdata;
  logic       scl_oe, sda_oe, busy_o, done_o;
  logic       slv_low = 1'b0, slv_nack = 1'b0;
  int         n_chk = 0, n_bad = 0;
  int         starts = 0, stops = 0, nrise = 0, nfall = 0, cyc = 0;
  logic [8:0] rx = '0;
  logic       scl_at2;

  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || slv_low);

  always #2 clk = !clk;

  i2c_bus_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .done_clr(done_clr), .clk_en(clk_en), .pad_off(pad_off), .qdiv(qdiv),
    .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy_o(busy_o),
    .done_o(done_o));

  always @(negedge sda_w) if (scl_w) starts++;
  always @(posedge sda_w) if (scl_w) stops++;
  always @(posedge scl_w) begin rx = {rx[7:0], sda_w}; nrise++; end
  always @(negedge scl_w) begin
    nfall++;
    slv_low = (nfall == 8) && !slv_nack;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] b);
    nfall = 0; nrise = 0;
    @(negedge clk); dat_wr = 1'b1; dat_wdata = b;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_done();
    cyc = 0;
    scl_at2 = 1'b0;
    while (!done_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) scl_at2 = scl_oe;
    end
  endtask

  function automatic int quarters_cycles(input int nq, input int dv);
    return nq * (dv + 1);
  endfunction

  task automatic clear_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b, input bit nk, input string tag);
    int s0;
    slv_nack = nk;
    s0 = starts;
    clear_done();
    wr_dat(b);
    chk(busy_o, {tag, " R9 busy after write"}, busy_o, 1);
    wait_done();
    chk(cyc == quarters_cycles(36, qdiv), {tag, " R6 byte cycles"}, cyc, quarters_cycles(36, qdiv));
    chk(rx[8:1] == b && nrise == 9, {tag, " R6 shifted bits"}, rx[8:1], b);
    chk(ctl_rdata[3] == nk && rx[0] == nk, {tag, " R7 ack capture"}, ctl_rdata[3], nk);
    chk(starts == s0, {tag, " R6 no stray start"}, starts, s0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] rb;
    logic       so, do_;
    int         s0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy_o && !done_o && ctl_rdata == 4'd0,
        "R1 reset state", {scl_oe, sda_oe, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr_ctl(4'b0001);
    chk(ctl_rdata == 4'b0001, "R2 enable readback", ctl_rdata, 1);

    qdiv = 8'd1;
    s0 = starts;
    wr_ctl(4'b0011);
    chk(busy_o, "R9 busy on start", busy_o, 1);
    wait_done();
    chk(cyc == quarters_cycles(4, 1), "R4 start cycles", cyc, 8);
    chk(starts == s0 + 1, "R4 start condition", starts, s0 + 1);
    @(negedge clk);
    chk(scl_oe && sda_oe && !busy_o, "R4 lines held low", {scl_oe, sda_oe}, 3);
    chk(scl_at2 == 1'b0, "R4 plain start keeps SCL released early", scl_at2, 0);

    pad_off = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R11 pad off floats lines", {scl_oe, sda_oe}, 0);
    pad_off = 1'b0;
    @(negedge clk);

    wr_ctl(4'b0001);
    chk(ctl_rdata[2:0] == 3'b001, "R2 no-action keeps enable", ctl_rdata, 1);

    do_byte(8'hA5, 1'b0, "directed ack");
    do_byte(8'h00, 1'b1, "directed nack");
    do_byte(8'hFF, 1'b0, "directed ones");
    for (int i = 0; i < 8; i++) begin
      qdiv = 8'($urandom_range(0, 3));
      do_byte(8'($urandom), 1'($urandom), "random byte");
    end

    qdiv = 8'd3;
    s0 = starts;
    clear_done();
    wr_ctl(4'b1011);
    wait_done();
    chk(cyc == quarters_cycles(4, 3), "R5 restart cycles", cyc, 16);
    chk(scl_at2 == 1'b1, "R5 SCL low in first quarter", scl_at2, 1);
    chk(starts == s0 + 1, "R5 restart condition", starts, s0 + 1);

    do_byte(8'h3C, 1'b0, "pre-busy");
    clear_done();
    wr_dat(8'h96);
    rb = ctl_rdata;
    s0 = stops;
    wr_ctl(4'b0101);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = 8'h11;
    @(negedge clk); dat_wr = 1'b0;
    wait_done();
    chk(rx[8:1] == 8'h96, "R3 byte write while busy dropped", rx[8:1], 8'h96);
    chk(stops == s0 && ctl_rdata[2:0] == rb[2:0], "R3 control write while busy dropped", stops, s0);
    @(negedge clk);
    chk(!busy_o, "R3 nothing queued", busy_o, 0);

    clear_done();
    wr_dat(8'hC3);
    repeat (7) @(negedge clk);
    clk_en = 1'b0;
    repeat (2) @(negedge clk);
    so = scl_oe; do_ = sda_oe;
    repeat (40) @(negedge clk);
    chk(busy_o && scl_oe == so && sda_oe == do_ && !done_o, "R10 stall freezes",
        {scl_oe, sda_oe}, {so, do_});
    clk_en = 1'b1;
    wait_done();
    chk(rx[8:1] == 8'hC3, "R10 byte intact after stall", rx[8:1], 8'hC3);

    wr_ctl(4'b0000);
    so = scl_oe; do_ = sda_oe;
    wr_dat(8'h5A);
    repeat (30) @(negedge clk);
    chk(!busy_o && nrise == 0 && scl_oe == so && sda_oe == do_, "R3 disabled byte ignored", nrise, 0);
    s0 = stops;
    wr_ctl(4'b0100);
    repeat (30) @(negedge clk);
    chk(!busy_o && stops == s0 && ctl_rdata[0] == 1'b0, "R3 disabled stop ignored", stops, s0);
    wr_ctl(4'b0001);

    qdiv = 8'd2;
    s0 = stops;
    clear_done();
    chk(!done_o, "R9 done cleared", done_o, 0);
    wr_ctl(4'b0101);
    wait_done();
    chk(cyc == quarters_cycles(4, 2), "R8 stop cycles", cyc, 12);
    chk(stops == s0 + 1, "R8 stop condition", stops, s0 + 1);
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
    repeat (5) @(negedge clk);
    chk(done_o, "R9 done sticky", done_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule